// File: doc/BRIEF.md
# Update strobe source selector

This block decides where the "update now" strobe for each port's counter group comes from, and produces that strobe together with the status flags that software watches. Three kinds of source exist. An external pin and an internal one-second tick are level signals that go high and later low. Software request bits are set by software and cleared again by software. A global select picks one of three global candidates. Each port then either follows that global choice or uses its own software bit. Each port's bit-error-rate tester either follows its port's choice or uses a local software bit of its own.

For every path the chosen level is delayed by two clock cycles and presented as a status flag. Software that drives a request bit waits for the matching flag to go high and then clears the bit, and the flag drops two cycles later. The strobe sent to a counter group or tester is a single-cycle pulse in the cycle the flag rises. A change to any select input is held back until the path is quiet, so a reconfiguration never fabricates or loses a strobe. The pin and tick inputs are taken to be synchronous to `clk`. The one-second timebase and the counters themselves are outside this block.

Top module: `upd_strobe_sel`

## Requirements
- R1: The global select `glb_sel_i` picks the global source by its code: 2'b00 takes `glb_sw_i`, 2'b01 takes `ext_pin_i`, and 2'b10 or 2'b11 take `sec_tick_i`. `glb_status_o` follows the global source and ignores the two inputs that are not chosen.
- R2: Port n takes the global source when `port_use_glb_i[n]` is 1 and its own `port_sw_i[n]` when it is 0. Each port's path is independent of the other ports.
- R3: The tester of port n takes port n's chosen source when `tst_use_port_i[n]` is 1 and its local `tst_sw_i[n]` when it is 0. `tst_status_o[n]` is its flag and `tst_strobe_o[n]` is its strobe.
- R4: Every status flag equals its path's chosen source level delayed by exactly two clock cycles, for both the rising and the falling edge.
- R5: Every strobe output is high for exactly one cycle per rising edge of its chosen source. That cycle is the cycle in which the matching status flag rises. A source held high produces no further strobes.
- R6: A new select value is adopted only in a cycle where the currently chosen source and the requested source are both low and no rising or falling level is still in the two-cycle delay. Until then the previous choice stays in force, and adopting a new choice never produces a strobe by itself.
- R7: Software handshake: after a request bit is set, its flag rises two cycles later. After the bit is then cleared, the flag falls two cycles later. The whole set-then-clear sequence yields exactly one strobe.
- R8: While `rst_n` is low, every output is low. After reset the effective selects are the software bit for the global path, the own bit for each port, and the local bit for each tester. Each select is then replaced by its input value at the first quiet cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | External update level, synchronous to clk |
| sec_tick_i | input | 1 | Internal one-second reference level |
| glb_sw_i | input | 1 | Global software request bit |
| glb_sel_i | input | 2 | Global source select code |
| port_sw_i | input | NUM_PORTS | Per-port software request bits |
| port_use_glb_i | input | NUM_PORTS | Per-port mode: 1 = global source, 0 = own bit |
| tst_sw_i | input | NUM_PORTS | Per-tester local software request bits |
| tst_use_port_i | input | NUM_PORTS | Per-tester mode: 1 = port source, 0 = local bit |
| glb_status_o | output | 1 | Global path status flag |
| glb_strobe_o | output | 1 | Global path single-cycle strobe |
| port_status_o | output | NUM_PORTS | Per-port status flags |
| port_strobe_o | output | NUM_PORTS | Per-port counter update strobes |
| tst_status_o | output | NUM_PORTS | Per-tester status flags |
| tst_strobe_o | output | NUM_PORTS | Per-tester update strobes |

## Verification
A stuck or wrongly loaded select register shows at the ports as a flag that follows the wrong input. The fault appears two cycles after that input rises, or as a flag that does not move when the chosen input rises. A fault in the delay stages moves a flag edge off its two-cycle position. It can also produce a strobe outside the cycle the flag rises, or a second strobe while the source stays high. Either symptom is visible within three cycles of the source edge. A select adopted too early shows up as a flag that drops, or a strobe that fires, straight after a mode change made while the old or new source was high.

// File: rtl/upd_strobe_pkg.sv
package upd_strobe_pkg;

    // Width of the global select code and the number of candidates it indexes.
    localparam int GLB_SEL_W = 2;
    localparam int GLB_SRC_N = 1 << GLB_SEL_W;

    typedef enum logic [GLB_SEL_W-1:0] {
        GSEL_SW    = 2'b00,
        GSEL_PIN   = 2'b01,
        GSEL_TICKA = 2'b10,
        GSEL_TICKB = 2'b11
    } glb_sel_e;

    // Two-stage level delay plus the registered rising-edge pulse.
    typedef struct packed {
        logic lvl1;
        logic lvl2;
        logic pulse;
    } trk_t;

endpackage

// File: rtl/upd_src_stage.sv
module upd_src_stage #(
    parameter int SEL_W = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [(1<<SEL_W)-1:0]    cand_i,
    input  logic [SEL_W-1:0]         sel_i,
    output logic                     src_o,
    output logic                     status_o,
    output logic                     strobe_o
);

    typedef struct packed {
        logic [SEL_W-1:0]      sel;
        upd_strobe_pkg::trk_t  trk;
    } st_t;

    st_t  st_q;
    st_t  st_d;
    logic cur_lvl;
    logic req_lvl;
    logic path_idle;

    always_comb begin
        cur_lvl   = cand_i[st_q.sel];
        req_lvl   = cand_i[sel_i];
        // Quiet: nothing high now, nothing high requested, nothing in flight.
        path_idle = !cur_lvl && !req_lvl && !st_q.trk.lvl1 && !st_q.trk.lvl2;

        st_d           = st_q;
        st_d.trk.lvl1  = cur_lvl;
        st_d.trk.lvl2  = st_q.trk.lvl1;
        st_d.trk.pulse = st_q.trk.lvl1 & ~st_q.trk.lvl2;
        if (path_idle) begin
            st_d.sel = sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_o    = cur_lvl;
    assign status_o = st_q.trk.lvl2;
    assign strobe_o = st_q.trk.pulse;

endmodule

// File: rtl/upd_strobe_sel.sv
module upd_strobe_sel #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_pin_i,
    input  logic                 sec_tick_i,
    input  logic                 glb_sw_i,
    input  logic [1:0]           glb_sel_i,
    input  logic [NUM_PORTS-1:0] port_sw_i,
    input  logic [NUM_PORTS-1:0] port_use_glb_i,
    input  logic [NUM_PORTS-1:0] tst_sw_i,
    input  logic [NUM_PORTS-1:0] tst_use_port_i,
    output logic                 glb_status_o,
    output logic                 glb_strobe_o,
    output logic [NUM_PORTS-1:0] port_status_o,
    output logic [NUM_PORTS-1:0] port_strobe_o,
    output logic [NUM_PORTS-1:0] tst_status_o,
    output logic [NUM_PORTS-1:0] tst_strobe_o
);
    import upd_strobe_pkg::*;

    logic [GLB_SRC_N-1:0] glb_cand;
    logic                 glb_src;
    logic [NUM_PORTS-1:0] port_src;

    always_comb begin
        glb_cand             = '0;
        glb_cand[GSEL_SW]    = glb_sw_i;
        glb_cand[GSEL_PIN]   = ext_pin_i;
        glb_cand[GSEL_TICKA] = sec_tick_i;
        glb_cand[GSEL_TICKB] = sec_tick_i;
    end

    upd_src_stage #(.SEL_W(GLB_SEL_W)) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand_i   (glb_cand),
        .sel_i    (glb_sel_i),
        .src_o    (glb_src),
        .status_o (glb_status_o),
        .strobe_o (glb_strobe_o)
    );

    for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
        logic tst_src_unused;

        // Candidate 1 is the upstream choice, candidate 0 the own bit.
        upd_src_stage #(.SEL_W(1)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .cand_i   ({glb_src, port_sw_i[n]}),
            .sel_i    (port_use_glb_i[n]),
            .src_o    (port_src[n]),
            .status_o (port_status_o[n]),
            .strobe_o (port_strobe_o[n])
        );

        upd_src_stage #(.SEL_W(1)) u_tst (
            .clk      (clk),
            .rst_n    (rst_n),
            .cand_i   ({port_src[n], tst_sw_i[n]}),
            .sel_i    (tst_use_port_i[n]),
            .src_o    (tst_src_unused),
            .status_o (tst_status_o[n]),
            .strobe_o (tst_strobe_o[n])
        );
    end

endmodule

// File: rtl/upd_strobe_sel_chk.sv
module upd_strobe_sel_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ext_pin_i,
    input logic                 sec_tick_i,
    input logic                 glb_sw_i,
    input logic [NUM_PORTS-1:0] port_sw_i,
    input logic [NUM_PORTS-1:0] tst_sw_i,
    input logic                 glb_status_o,
    input logic                 glb_strobe_o,
    input logic [NUM_PORTS-1:0] port_status_o,
    input logic [NUM_PORTS-1:0] port_strobe_o,
    input logic [NUM_PORTS-1:0] tst_status_o,
    input logic [NUM_PORTS-1:0] tst_strobe_o
);

    // R1: the global flag can only rise if some global candidate was high two cycles earlier.
    p_glb_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glb_status_o) |-> $past(glb_sw_i | ext_pin_i | sec_tick_i, 2));

    p_glb_strobe_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        glb_strobe_o |-> $rose(glb_status_o));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        p_port_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_status_o[i]) |->
                $past(port_sw_i[i] | glb_sw_i | ext_pin_i | sec_tick_i, 2));

        p_tst_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tst_status_o[i]) |->
                $past(tst_sw_i[i] | port_sw_i[i] | glb_sw_i | ext_pin_i | sec_tick_i, 2));

        p_port_strobe_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            port_strobe_o[i] |=> !port_strobe_o[i]);

        p_port_strobe_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            port_strobe_o[i] |-> $rose(port_status_o[i]));

        p_port_rise_has_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_status_o[i]) |-> port_strobe_o[i]);

        p_tst_strobe_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tst_strobe_o[i] |-> $rose(tst_status_o[i]));
    end

endmodule

bind upd_strobe_sel upd_strobe_sel_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_pin_i     (ext_pin_i),
    .sec_tick_i    (sec_tick_i),
    .glb_sw_i      (glb_sw_i),
    .port_sw_i     (port_sw_i),
    .tst_sw_i      (tst_sw_i),
    .glb_status_o  (glb_status_o),
    .glb_strobe_o  (glb_strobe_o),
    .port_status_o (port_status_o),
    .port_strobe_o (port_strobe_o),
    .tst_status_o  (tst_status_o),
    .tst_strobe_o  (tst_strobe_o)
);

// File: tb/upd_strobe_sel_tb.sv
module upd_strobe_sel_tb;

    localparam int CLK_P = 10;
    localparam int NP    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_pin = 1'b0;
    logic          sec_tick = 1'b0;
    logic          glb_sw = 1'b0;
    logic [1:0]    glb_sel = 2'b00;
    logic [NP-1:0] port_sw = '0;
    logic [NP-1:0] port_use_glb = '0;
    logic [NP-1:0] tst_sw = '0;
    logic [NP-1:0] tst_use_port = '0;
    logic          glb_status;
    logic          glb_strobe;
    logic [NP-1:0] port_status;
    logic [NP-1:0] port_strobe;
    logic [NP-1:0] tst_status;
    logic [NP-1:0] tst_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    int pcnt [NP];
    int tcnt [NP];
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    upd_strobe_sel #(.NUM_PORTS(NP)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_pin_i      (ext_pin),
        .sec_tick_i     (sec_tick),
        .glb_sw_i       (glb_sw),
        .glb_sel_i      (glb_sel),
        .port_sw_i      (port_sw),
        .port_use_glb_i (port_use_glb),
        .tst_sw_i       (tst_sw),
        .tst_use_port_i (tst_use_port),
        .glb_status_o   (glb_status),
        .glb_strobe_o   (glb_strobe),
        .port_status_o  (port_status),
        .port_strobe_o  (port_strobe),
        .tst_status_o   (tst_status),
        .tst_strobe_o   (tst_strobe)
    );

    // Strobes are one clock wide, so a falling-edge sample sees each once.
    always @(negedge clk) begin
        for (int i = 0; i < NP; i++) begin
            if (port_strobe[i]) pcnt[i]++;
            if (tst_strobe[i])  tcnt[i]++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr_cnt();
        for (int i = 0; i < NP; i++) begin
            pcnt[i] = 0;
            tcnt[i] = 0;
        end
    endtask

    task automatic quiet_all();
        @(negedge clk);
        ext_pin  = 1'b0;
        sec_tick = 1'b0;
        glb_sw   = 1'b0;
        port_sw  = '0;
        tst_sw   = '0;
        cyc(4);
    endtask

    task automatic t_reset();
        cyc(2);
        chk(glb_status == 1'b0 && glb_strobe == 1'b0, "R8 glb in reset", glb_status, 0);
        chk(port_status == '0 && port_strobe == '0, "R8 port in reset", port_status, 0);
        chk(tst_status == '0 && tst_strobe == '0, "R8 tst in reset", tst_status, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2);
        clr_cnt();
        @(negedge clk);
        tst_sw[0] = 1'b1;
        cyc(3);
        chk(tst_status[0] == 1'b1, "R8 tester local after reset", tst_status[0], 1);
        chk(tcnt[0] == 1, "R8 tester strobe after reset", tcnt[0], 1);
        quiet_all();
    endtask

    task automatic t_glb_sel();
        @(negedge clk);
        glb_sel = 2'b00;
        port_use_glb = '1;
        cyc(4);
        @(negedge clk); glb_sw = 1'b1;
        cyc(2);
        chk(glb_status == 1'b1, "R1 code 00 takes sw bit", glb_status, 1);
        chk(port_status == '1, "R2 ports follow global", port_status, 15);
        @(negedge clk); glb_sw = 1'b0;
        cyc(3);
        @(negedge clk); ext_pin = 1'b1;
        cyc(3);
        chk(glb_status == 1'b0, "R1 code 00 ignores pin", glb_status, 0);
        quiet_all();
        @(negedge clk); glb_sel = 2'b01;
        cyc(4);
        @(negedge clk); ext_pin = 1'b1;
        cyc(2);
        chk(glb_status == 1'b1, "R1 code 01 takes pin", glb_status, 1);
        @(negedge clk); ext_pin = 1'b0; glb_sw = 1'b1;
        cyc(3);
        chk(glb_status == 1'b0, "R1 code 01 ignores sw", glb_status, 0);
        @(negedge clk); glb_sw = 1'b0; sec_tick = 1'b1;
        cyc(3);
        chk(glb_status == 1'b0, "R1 code 01 ignores tick", glb_status, 0);
        quiet_all();
        for (int c = 2; c < 4; c++) begin
            @(negedge clk); glb_sel = c[1:0];
            cyc(4);
            @(negedge clk); sec_tick = 1'b1;
            cyc(2);
            chk(glb_status == 1'b1, "R1 code 1X takes tick", c, 1);
            @(negedge clk); sec_tick = 1'b0; ext_pin = 1'b1;
            cyc(3);
            chk(glb_status == 1'b0, "R1 code 1X ignores pin", c, 0);
            quiet_all();
        end
        @(negedge clk); glb_sel = 2'b00;
        cyc(4);
    endtask

    task automatic t_timing();
        @(negedge clk); port_use_glb = '0;
        cyc(4);
        clr_cnt();
        @(negedge clk); port_sw[0] = 1'b1;
        cyc(1);
        chk(port_status[0] == 1'b0 && port_strobe[0] == 1'b0, "R4 one cycle no flag", port_status[0], 0);
        cyc(1);
        chk(port_status[0] == 1'b1, "R4 flag after two cycles", port_status[0], 1);
        chk(port_strobe[0] == 1'b1, "R5 strobe with flag rise", port_strobe[0], 1);
        cyc(1);
        chk(port_strobe[0] == 1'b0, "R5 strobe one cycle", port_strobe[0], 0);
        cyc(5);
        chk(pcnt[0] == 1, "R5 one strobe while held", pcnt[0], 1);
        @(negedge clk); port_sw[0] = 1'b0;
        cyc(1);
        chk(port_status[0] == 1'b1, "R4 flag holds one cycle", port_status[0], 1);
        cyc(1);
        chk(port_status[0] == 1'b0, "R4 flag falls after two", port_status[0], 0);
        cyc(2);
    endtask

    task automatic t_port_mode();
        @(negedge clk); port_use_glb = 4'b0010;
        cyc(4);
        clr_cnt();
        @(negedge clk); glb_sw = 1'b1;
        cyc(3);
        chk(port_status == 4'b0010, "R2 only global-mode port", port_status, 2);
        @(negedge clk); glb_sw = 1'b0; port_sw = 4'b0100;
        cyc(3);
        chk(port_status == 4'b0100, "R2 own bit port only", port_status, 4);
        quiet_all();
        chk(pcnt[1] == 1 && pcnt[2] == 1 && pcnt[0] == 0, "R2 strobe counts", pcnt[1] + pcnt[2] + pcnt[0], 2);
        @(negedge clk); port_use_glb = '0;
        cyc(4);
    endtask

    task automatic t_tester();
        @(negedge clk); tst_use_port = 4'b0001;
        cyc(4);
        clr_cnt();
        @(negedge clk); port_sw[0] = 1'b1;
        cyc(3);
        chk(tst_status[1:0] == 2'b01, "R3 tester follows port", tst_status[1:0], 1);
        @(negedge clk); port_sw[0] = 1'b0;
        cyc(4);
        @(negedge clk); tst_sw = 4'b0011;
        cyc(3);
        chk(tst_status[1:0] == 2'b10, "R3 tester local bit", tst_status[1:0], 2);
        quiet_all();
        chk(tcnt[0] == 1 && tcnt[1] == 1, "R3 tester strobes", tcnt[0] + tcnt[1], 2);
        @(negedge clk); tst_use_port = '0;
        cyc(4);
    endtask

    task automatic t_defer();
        clr_cnt();
        @(negedge clk); port_sw[3] = 1'b1;
        cyc(4);
        @(negedge clk); port_use_glb[3] = 1'b1;
        cyc(4);
        chk(port_status[3] == 1'b1, "R6 held while own bit high", port_status[3], 1);
        @(negedge clk); port_sw[3] = 1'b0;
        cyc(6);
        chk(port_status[3] == 1'b0 && pcnt[3] == 1, "R6 no strobe on switch", pcnt[3], 1);
        @(negedge clk); glb_sw = 1'b1;
        cyc(3);
        chk(port_status[3] == 1'b1 && pcnt[3] == 2, "R6 switched to global", pcnt[3], 2);
        @(negedge clk); port_use_glb[3] = 1'b0;
        cyc(4);
        chk(port_status[3] == 1'b1, "R6 held while global high", port_status[3], 1);
        @(negedge clk); glb_sw = 1'b0;
        cyc(6);
        chk(port_status[3] == 1'b0 && pcnt[3] == 2, "R6 switch back silent", pcnt[3], 2);
        @(negedge clk); glb_sw = 1'b1;
        cyc(3);
        chk(port_status[3] == 1'b0, "R6 back on own bit", port_status[3], 0);
        @(negedge clk); port_use_glb[3] = 1'b1;
        cyc(4);
        chk(port_status[3] == 1'b0 && pcnt[3] == 2, "R6 no switch into high source", pcnt[3], 2);
        @(negedge clk); glb_sw = 1'b0;
        cyc(4);
        @(negedge clk); glb_sw = 1'b1;
        cyc(3);
        chk(port_status[3] == 1'b1 && pcnt[3] == 3, "R6 adopted once quiet", pcnt[3], 3);
        quiet_all();
        @(negedge clk); port_use_glb = '0;
        cyc(4);
    endtask

    task automatic t_handshake();
        int n;
        clr_cnt();
        @(negedge clk); port_sw[2] = 1'b1;
        n = 0;
        do begin
            cyc(1);
            n++;
        end while (!port_status[2] && n < 20);
        chk(n == 2, "R7 flag rises after set", n, 2);
        @(negedge clk); port_sw[2] = 1'b0;
        n = 0;
        do begin
            cyc(1);
            n++;
        end while (port_status[2] && n < 20);
        chk(n == 2, "R7 flag falls after clear", n, 2);
        cyc(3);
        chk(pcnt[2] == 1, "R7 one strobe per handshake", pcnt[2], 1);
    endtask

    initial begin
        clr_cnt();
        t_reset();
        t_glb_sel();
        t_timing();
        t_port_mode();
        t_tester();
        t_defer();
        t_handshake();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule